// File: doc/BRIEF.md
# Pin-Change and External Interrupt Controller

This block watches two groups of general-purpose input pins and one dedicated external interrupt pin, and turns activity on them into interrupt requests for a small CPU core. Every pin input passes through a two-stage synchronizer. A change is detected by comparing the synchronized level with its value one cycle earlier. Each pin of the two pin-change groups (a lower group of 8 pins and an upper group of 4 pins) has its own mask bit. Each group has one sticky flag and one enable bit.

The external pin has a 2-bit sense control. It can trigger on a low level, on any change, on a falling edge or on a rising edge. In low-level mode the request follows the synchronized pin level, and the external flag is held at zero. Flags are cleared by writing a one to them, or by the acknowledge input that the core raises when it takes the matching vector. A request leaves the block only when the source is active, its enable bit is set and the global interrupt-enable input is high.

Software reaches the flag, enable and mask registers through a byte-wide register port. Writes take effect on a clock edge, and reads are combinational.

Top module: `pcx_irq_ctrl`

## Requirements
- R1: After reset every flag, enable and mask bit is zero, all four registers read 0x00 and `irq_o` is 0.
- R2: A transition on a lower-group pin whose bit is set in the lower mask register (address 2, bit i for pin i) sets the lower flag (address 0, bit 4) on the third rising clock edge after the pin changes, and not earlier.
- R3: A transition on an upper-group pin whose bit is set in the upper mask register (address 3, bits 3:0) sets the upper flag (address 0, bit 5) with the same three-edge latency. Bits 7:4 of address 3 read zero.
- R4: A transition on a pin whose mask bit is clear never sets its group flag.
- R5: `irq_o[k]` is high exactly when source k is active, enable bit k is set and `gie_i` is high. Index 0 is the lower group, 1 the upper group and 2 the external pin. The enable register at address 1 holds these enables in bits 4, 5 and 6.
- R6: Writing a one to a flag bit at address 0 clears that flag on the write edge. Writing a zero leaves it unchanged.
- R7: A one-cycle pulse on `ack_i[k]` clears the flag of source k on that edge.
- R8: When a set event meets a write-one-to-clear or an acknowledge in the same cycle, the flag ends up set.
- R9: With `ext_sense_i` set to 01 any change sets the external flag (address 0, bit 6). With 10 only a falling transition sets it, and with 11 only a rising transition sets it.
- R10: With `ext_sense_i` set to 00, the external flag reads zero at once and is cleared. Source 2 is active while the synchronized pin is low, two edges after the pin moves. A flag set earlier does not come back when an edge mode is selected again.
- R11: Reserved bits read as zero: bits 7 and 3:0 at address 0, and every bit of address 1 except bits 6:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lo_pins_i | input | 8 | Lower pin-change group inputs |
| hi_pins_i | input | 4 | Upper pin-change group inputs |
| ext_pin_i | input | 1 | External interrupt pin |
| ext_sense_i | input | 2 | External sense: 00 low level, 01 any change, 10 falling, 11 rising |
| gie_i | input | 1 | Global interrupt enable from the core |
| ack_i | input | 3 | Vector acknowledge, one bit per source |
| reg_addr_i | input | 2 | Register address: 0 flags, 1 enables, 2 lower mask, 3 upper mask |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data of the addressed register |
| irq_o | output | 3 | Interrupt requests, one bit per source |

## Verification
A wrong synchronizer or change-detect stage shows at the flag register as a flag that sets one edge early or late, or never sets at all. The bench therefore samples the flags both just before and just after the third edge. A flag register that lost the set-over-clear priority shows as a cleared flag on the very edge where a new change meets a clear. A gating fault shows on `irq_o` as soon as the enables or `gie_i` move. A level-mode fault appears as a nonzero external flag bit right after the mode switch, or as a request that misses the two-edge level latency.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

  localparam int REG_W = 8;
  localparam int N_SRC = 3;

  // source indices, shared by ack_i, irq_o and the enable register
  localparam int SRC_LO  = 0;
  localparam int SRC_HI  = 1;
  localparam int SRC_EXT = 2;

  // bit positions in the flag and enable registers
  localparam int FLG_LO  = 4;
  localparam int FLG_HI  = 5;
  localparam int FLG_EXT = 6;

  localparam logic [1:0] ADDR_FLAG  = 2'd0;
  localparam logic [1:0] ADDR_ENA   = 2'd1;
  localparam logic [1:0] ADDR_MASKL = 2'd2;
  localparam logic [1:0] ADDR_MASKU = 2'd3;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

endpackage

// File: rtl/pcx_rst_sync.sv
module pcx_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_no = s2_q;
endmodule

// File: rtl/pcx_sync.sv
module pcx_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;
  logic [W-1:0] s1_d, s2_d, prev_d;

  always_comb begin
    s1_d   = d_i;
    s2_d   = s1_q;
    prev_d = s2_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      prev_q <= prev_d;
    end
  end

  assign lvl_o = s2_q;
  assign chg_o = s2_q ^ prev_q;

  // R2
  chg_pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_o != '0) |=> ((chg_o & $past(chg_o)) == '0) || ($past(s1_q) != $past(s2_q)));
endmodule

// File: rtl/pcx_group.sv
module pcx_group #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] chg_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wd_i,
  input  logic         clr_i,
  input  logic         ack_i,
  output logic [W-1:0] mask_o,
  output logic         flag_o
);
  logic [W-1:0] mask_q, mask_d;
  logic         flag_q, flag_d;
  logic         hit;

  always_comb begin
    mask_d = mask_q;
    if (mask_we_i) mask_d = mask_wd_i;
    hit    = |(chg_i & mask_q);
    flag_d = flag_q;
    if (clr_i || ack_i) flag_d = 1'b0;
    if (hit)            flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      flag_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      flag_q <= flag_d;
    end
  end

  assign mask_o = mask_q;
  assign flag_o = flag_q;

  // R8
  hit_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> flag_q);

  // R4
  no_hit_stays_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit && !flag_q) |=> !flag_q);

  // R6
  clear_takes_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i || ack_i) && !hit) |=> !flag_q);
endmodule

// File: rtl/pcx_ext.sv
module pcx_ext
  import pcx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic       chg_i,
  input  logic [1:0] sense_i,
  input  logic       clr_i,
  input  logic       ack_i,
  output logic       flag_o,
  output logic       level_act_o
);
  logic flag_q, flag_d;
  logic set_ev;
  logic is_level;

  always_comb begin
    is_level = (sense_i == SENSE_LOW);
    unique case (sense_i)
      SENSE_ANY:  set_ev = chg_i;
      SENSE_FALL: set_ev = chg_i & ~lvl_i;
      SENSE_RISE: set_ev = chg_i &  lvl_i;
      default:    set_ev = 1'b0;
    endcase
    flag_d = flag_q;
    if (clr_i || ack_i) flag_d = 1'b0;
    if (set_ev)         flag_d = 1'b1;
    if (is_level)       flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o      = flag_q & ~is_level;
  assign level_act_o = is_level & ~lvl_i;

  // R10
  level_flag_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i == SENSE_LOW) |=> !flag_q);

  // R9
  rise_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i == SENSE_RISE && chg_i && lvl_i) |=> flag_q);

  // R9
  fall_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i == SENSE_FALL && chg_i && !lvl_i) |=> flag_q);
endmodule

// File: rtl/pcx_irq_ctrl.sv
module pcx_irq_ctrl
  import pcx_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LO_W-1:0]  lo_pins_i,
  input  logic [HI_W-1:0]  hi_pins_i,
  input  logic             ext_pin_i,
  input  logic [1:0]       ext_sense_i,
  input  logic             gie_i,
  input  logic [N_SRC-1:0] ack_i,
  input  logic [1:0]       reg_addr_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic [N_SRC-1:0] irq_o
);
  logic             rst_n;
  logic [LO_W-1:0]  lo_chg, lo_lvl, lo_mask;
  logic [HI_W-1:0]  hi_chg, hi_lvl, hi_mask;
  logic             ext_chg, ext_lvl;
  logic             lo_flag, hi_flag, ext_flag, ext_level_act;
  logic             wr_flag, wr_ena, wr_maskl, wr_masku;
  logic [N_SRC-1:0] en_q, en_d;
  logic [N_SRC-1:0] src_act;
  logic [REG_W-1:0] lo_mask_rd, hi_mask_rd;

  pcx_rst_sync u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n));

  pcx_sync #(.W(LO_W)) u_sync_lo (
    .clk_i(clk_i), .rst_ni(rst_n), .d_i(lo_pins_i), .lvl_o(lo_lvl), .chg_o(lo_chg));
  pcx_sync #(.W(HI_W)) u_sync_hi (
    .clk_i(clk_i), .rst_ni(rst_n), .d_i(hi_pins_i), .lvl_o(hi_lvl), .chg_o(hi_chg));
  pcx_sync #(.W(1)) u_sync_ext (
    .clk_i(clk_i), .rst_ni(rst_n), .d_i(ext_pin_i), .lvl_o(ext_lvl), .chg_o(ext_chg));

  always_comb begin
    wr_flag  = reg_we_i && (reg_addr_i == ADDR_FLAG);
    wr_ena   = reg_we_i && (reg_addr_i == ADDR_ENA);
    wr_maskl = reg_we_i && (reg_addr_i == ADDR_MASKL);
    wr_masku = reg_we_i && (reg_addr_i == ADDR_MASKU);
  end

  pcx_group #(.W(LO_W)) u_grp_lo (
    .clk_i(clk_i), .rst_ni(rst_n), .chg_i(lo_chg),
    .mask_we_i(wr_maskl), .mask_wd_i(reg_wdata_i[LO_W-1:0]),
    .clr_i(wr_flag & reg_wdata_i[FLG_LO]), .ack_i(ack_i[SRC_LO]),
    .mask_o(lo_mask), .flag_o(lo_flag));

  pcx_group #(.W(HI_W)) u_grp_hi (
    .clk_i(clk_i), .rst_ni(rst_n), .chg_i(hi_chg),
    .mask_we_i(wr_masku), .mask_wd_i(reg_wdata_i[HI_W-1:0]),
    .clr_i(wr_flag & reg_wdata_i[FLG_HI]), .ack_i(ack_i[SRC_HI]),
    .mask_o(hi_mask), .flag_o(hi_flag));

  pcx_ext u_ext (
    .clk_i(clk_i), .rst_ni(rst_n), .lvl_i(ext_lvl), .chg_i(ext_chg),
    .sense_i(ext_sense_i), .clr_i(wr_flag & reg_wdata_i[FLG_EXT]),
    .ack_i(ack_i[SRC_EXT]), .flag_o(ext_flag), .level_act_o(ext_level_act));

  // enable register: next state and register
  always_comb begin
    en_d = en_q;
    if (wr_ena) en_d = reg_wdata_i[FLG_EXT:FLG_LO];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  // request gating, one identical stage per source
  assign src_act[SRC_LO]  = lo_flag;
  assign src_act[SRC_HI]  = hi_flag;
  assign src_act[SRC_EXT] = ext_flag | ext_level_act;

  for (genvar k = 0; k < N_SRC; k++) begin : g_req
    assign irq_o[k] = gie_i & en_q[k] & src_act[k];
  end

  // read path
  always_comb begin
    lo_mask_rd = '0;
    lo_mask_rd[LO_W-1:0] = lo_mask;
    hi_mask_rd = '0;
    hi_mask_rd[HI_W-1:0] = hi_mask;
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_FLAG: begin
        reg_rdata_o[FLG_LO]  = lo_flag;
        reg_rdata_o[FLG_HI]  = hi_flag;
        reg_rdata_o[FLG_EXT] = ext_flag;
      end
      ADDR_ENA:   reg_rdata_o[FLG_EXT:FLG_LO] = en_q;
      ADDR_MASKL: reg_rdata_o = lo_mask_rd;
      default:    reg_rdata_o = hi_mask_rd;
    endcase
  end

  // R5
  req_needs_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (irq_o != '0) |-> gie_i);

  // R11
  flag_reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_addr_i == ADDR_FLAG) |-> (reg_rdata_o[7] == 1'b0 && reg_rdata_o[3:0] == 4'd0));

  // R3
  hi_mask_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_addr_i == ADDR_MASKU) |-> ((reg_rdata_o >> HI_W) == '0));

  // R7
  ack_clears_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ack_i[SRC_LO] && (lo_chg & lo_mask) == '0) |=> !lo_flag);
endmodule

// File: tb/test_pcx_irq_ctrl.sv
module test_pcx_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] lo_pins;
  logic [3:0] hi_pins;
  logic       ext_pin;
  logic [1:0] sense;
  logic       gie;
  logic [2:0] ack;
  logic [1:0] addr;
  logic       we;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [2:0] irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  pcx_irq_ctrl i_pcx_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .lo_pins_i(lo_pins), .hi_pins_i(hi_pins),
    .ext_pin_i(ext_pin), .ext_sense_i(sense), .gie_i(gie), .ack_i(ack),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq));

  always #5 clk = ~clk;

  function automatic logic grp_hit(logic [7:0] o, logic [7:0] n, logic [7:0] m);
    return |((o ^ n) & m);
  endfunction

  function automatic logic [2:0] exp_irq(logic [2:0] act, logic [2:0] en, logic g);
    return act & en & {3{g}};
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [1:0] a, logic [7:0] exp);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0; lo_pins = '0; hi_pins = '0; ext_pin = 1'b0;
    sense = 2'b11; gie = 1'b0; ack = '0; addr = '0; we = 1'b0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 flags", 2'd0, 8'h00);
    rd_chk("R1 enables", 2'd1, 8'h00);
    rd_chk("R1 lower mask", 2'd2, 8'h00);
    rd_chk("R1 upper mask", 2'd3, 8'h00);
    check("R1 irq", {5'b0, irq}, 8'h00);

    // R2 latency of lower group flag
    wr(2'd2, 8'h01);
    lo_pins = 8'h01;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd_chk("R2 flag before third edge", 2'd0, 8'h00);
    @(posedge clk);
    @(negedge clk);
    rd_chk("R2 flag after third edge", 2'd0, 8'h10);

    // R6 write-zero ignored, write-one clears
    wr(2'd0, 8'h00);
    rd_chk("R6 write zero", 2'd0, 8'h10);
    wr(2'd0, 8'h10);
    rd_chk("R6 write one", 2'd0, 8'h00);

    // R4 masked pins
    lo_pins = 8'h03;
    settle();
    rd_chk("R4 masked lower pin", 2'd0, 8'h00);
    hi_pins = 4'h1;
    settle();
    rd_chk("R4 masked upper pin", 2'd0, 8'h00);

    // R3 upper group
    wr(2'd3, 8'hFF);
    rd_chk("R3 upper mask readback", 2'd3, 8'h0F);
    hi_pins = 4'h5;
    settle();
    rd_chk("R3 upper flag", 2'd0, 8'h20);

    // R5 gating
    check("R5 no enable", {5'b0, irq}, 8'h00);
    wr(2'd1, 8'h20);
    check("R5 gie low", {5'b0, irq}, 8'h00);
    gie = 1'b1;
    #1;
    check("R5 upper request", {5'b0, irq}, 8'h02);
    wr(2'd1, 8'h10);
    check("R5 other enable", {5'b0, irq}, 8'h00);
    wr(2'd1, 8'hFF);
    rd_chk("R11 enable reserved bits", 2'd1, 8'h70);
    check("R5 all enabled", {5'b0, irq}, 8'h02);

    // R7 acknowledge
    @(negedge clk) ack = 3'b010;
    @(posedge clk);
    @(negedge clk) ack = 3'b000;
    rd_chk("R7 ack upper", 2'd0, 8'h00);
    lo_pins = 8'h02;
    settle();
    check("R7 lower request", {5'b0, irq}, 8'h01);
    ack = 3'b001;
    @(posedge clk);
    @(negedge clk) ack = 3'b000;
    rd_chk("R7 ack lower", 2'd0, 8'h00);

    // R8 set beats write-one-to-clear and acknowledge
    lo_pins = 8'h03;
    settle();
    lo_pins = 8'h02;
    repeat (2) @(posedge clk);
    @(negedge clk);
    addr = 2'd0; wdata = 8'h10; we = 1'b1;
    @(posedge clk);
    @(negedge clk) we = 1'b0;
    rd_chk("R8 set beats clear", 2'd0, 8'h10);
    lo_pins = 8'h03;
    repeat (2) @(posedge clk);
    @(negedge clk) ack = 3'b001;
    @(posedge clk);
    @(negedge clk) ack = 3'b000;
    rd_chk("R8 set beats ack", 2'd0, 8'h10);
    wr(2'd0, 8'h10);
    rd_chk("R8 cleared", 2'd0, 8'h00);

    // R9 external edge modes
    ext_pin = 1'b1;
    settle();
    rd_chk("R9 rise mode rising", 2'd0, 8'h40);
    check("R9 ext request", {5'b0, irq}, 8'h04);
    wr(2'd0, 8'h40);
    ext_pin = 1'b0;
    settle();
    rd_chk("R9 rise mode falling", 2'd0, 8'h00);
    sense = 2'b10;
    ext_pin = 1'b1;
    settle();
    rd_chk("R9 fall mode rising", 2'd0, 8'h00);
    ext_pin = 1'b0;
    settle();
    rd_chk("R9 fall mode falling", 2'd0, 8'h40);
    wr(2'd0, 8'h40);
    sense = 2'b01;
    ext_pin = 1'b1;
    settle();
    rd_chk("R9 any mode rising", 2'd0, 8'h40);
    wr(2'd0, 8'h40);
    ext_pin = 1'b0;
    settle();
    rd_chk("R9 any mode falling", 2'd0, 8'h40);
    wr(2'd0, 8'h40);

    // R10 level mode
    ext_pin = 1'b1;
    settle();
    rd_chk("R10 flag set before switch", 2'd0, 8'h40);
    sense = 2'b00;
    #1;
    rd_chk("R10 flag masked at once", 2'd0, 8'h00);
    check("R10 pin high no request", {5'b0, irq}, 8'h00);
    @(negedge clk);
    ext_pin = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10 level latency one edge", {5'b0, irq}, 8'h00);
    @(posedge clk);
    @(negedge clk);
    check("R10 level request", {5'b0, irq}, 8'h04);
    rd_chk("R10 flag zero while low", 2'd0, 8'h00);
    ext_pin = 1'b1;
    settle();
    check("R10 request released", {5'b0, irq}, 8'h00);
    sense = 2'b11;
    settle();
    rd_chk("R10 old flag not restored", 2'd0, 8'h00);

    // R2 R3 R4 R5 random masks, pins and gating
    for (int i = 0; i < 60; i++) begin
      logic [7:0] ml, nl;
      logic [3:0] mh, nh;
      logic [2:0] en;
      logic       g, fl, fh;
      ml = 8'($urandom); mh = 4'($urandom); en = 3'($urandom); g = 1'($urandom);
      nl = 8'($urandom); nh = 4'($urandom);
      wr(2'd2, ml);
      wr(2'd3, {4'h0, mh});
      wr(2'd1, {1'b0, en, 4'h0});
      wr(2'd0, 8'h70);
      gie = g;
      fl = grp_hit(lo_pins, nl, ml);
      fh = grp_hit({4'h0, hi_pins}, {4'h0, nh}, {4'h0, mh});
      lo_pins = nl;
      hi_pins = nh;
      settle();
      rd_chk("R2 R3 R4 random flags", 2'd0, {2'b00, fh, fl, 4'h0});
      check("R5 random gating", {5'b0, irq}, {5'b0, exp_irq({1'b0, fh, fl}, en, g)});
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule